// File: doc/BRIEF.md
# BCD Time and Date Alarm Comparator

This block sits beside a real-time counter that keeps seconds, minutes, hours, month and date in packed BCD. It holds a time-alarm word and a date-alarm word, each field carrying its own enable bit in the top bit of its byte. On every one-second tick the block compares each enabled alarm field with the live counter. When all enabled fields agree, it sets a sticky alarm flag.

Software clears the flag by writing a one to it. It routes the flag to an interrupt pin through a mask. The mask is set and cleared by writing ones to separate enable and disable addresses, and software can only read it. The date-alarm word has no year or century field, so an alarm can repeat every year. A field that is enabled but holds an illegal BCD value is reported in a validity word, and it stops the alarm from firing.

The register port is a simple synchronous bus with a 3-bit address. The addresses are: 0 time alarm, 1 date alarm, 2 status, 3 status clear, 4 interrupt enable, 5 interrupt disable, 6 mask, 7 validity. Read data is registered and appears one cycle after the address is applied.

Top module: `rtc_alarm_match`

## Requirements
- R1: The time-alarm word (address 0) keeps seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16, with enables at bits 7, 15 and 23. Every other bit reads back 0, so writing all ones reads back 0x00BFFFFF.
- R2: The date-alarm word (address 1) keeps month in bits 20:16 and date in bits 29:24, with enables at bits 23 and 31. It has no year or century storage, so writing all ones reads back 0xBF9F0000. The year and century bits of the live calendar input have no effect on the match.
- R3: On a clock edge where the one-second tick is high, the alarm flag is set if every enabled field equals the matching live field. A field whose enable is clear never prevents the match. Without the tick, the flag never sets.
- R4: When no field enable is set, the flag never sets.
- R5: Address 7 reports the time-alarm word as invalid in bit 0 and the date-alarm word as invalid in bit 1. A word is invalid when one of its enabled fields holds a digit above 9, seconds or minutes above 59, hours above 23, a month outside 01 to 12, or a date outside 01 to 31. While either bit is set, the flag cannot be set.
- R6: The flag reads at status bit 1 (address 2). Writing a 1 to bit 1 of address 3 clears it, and writing 0 there has no effect. If a tick match and a clear fall in the same cycle, the set wins.
- R7: Writing a 1 to bit 1 of address 4 sets mask bit 1, and writing a 1 to bit 1 of address 5 clears it. The mask reads at address 6, and writes to address 6 have no effect.
- R8: The interrupt output is high exactly when the flag and mask bit 1 are both set. It changes on the same clock edge as the flag or mask that drives it.
- R9: After a synchronous reset, every register reads 0 and the interrupt output is low.
- R10: Once set, the flag stays set until it is cleared. After a clear it does not return until a later tick finds a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe, once per counted second |
| cur_time | input | 24 | Live BCD time: seconds 6:0, minutes 14:8, hours 21:16 |
| cur_cal | input | 32 | Live BCD calendar: month 20:16, date 29:24, other fields ignored |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data, one cycle after rd_addr |
| irq | output | 1 | Alarm interrupt, flag AND mask |

## Verification
The assertions assume that the tick is a single-cycle strobe and that only one register write occurs per cycle. This means an enable write and a disable write never coincide. The bench drives every input on the falling edge and holds the tick for exactly one cycle. It issues writes one at a time, so the assertions only see traffic of this kind. The live counter inputs stay stable around each tick, so a match is decided against a known value.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int REG_AW  = 3;
  localparam int REG_DW  = 32;
  localparam int NFIELD  = 5;
  localparam int ALM_BIT = 1;

  localparam logic [REG_AW-1:0] A_TALM  = 3'd0;
  localparam logic [REG_AW-1:0] A_CALM  = 3'd1;
  localparam logic [REG_AW-1:0] A_STAT  = 3'd2;
  localparam logic [REG_AW-1:0] A_SCLR  = 3'd3;
  localparam logic [REG_AW-1:0] A_IEN   = 3'd4;
  localparam logic [REG_AW-1:0] A_IDIS  = 3'd5;
  localparam logic [REG_AW-1:0] A_MASK  = 3'd6;
  localparam logic [REG_AW-1:0] A_VALID = 3'd7;

  localparam logic [REG_DW-1:0] TALM_KEEP = 32'h00BF_FFFF;
  localparam logic [REG_DW-1:0] CALM_KEEP = 32'hBF9F_0000;

  // field order: sec, min, hour, month, date
  localparam logic [REG_DW-1:0] FLD_MASK [NFIELD] =
    '{32'h0000_007F, 32'h0000_7F00, 32'h003F_0000, 32'h001F_0000, 32'h3F00_0000};
  localparam int FLD_EN  [NFIELD] = '{7, 15, 23, 23, 31};
  localparam int FLD_CAL [NFIELD] = '{0, 0, 0, 1, 1};

  function automatic logic bcd_in_range(input logic [7:0] v,
                                        input logic [7:0] lo,
                                        input logic [7:0] hi);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  output logic [REG_DW-1:0] talm,
  output logic [REG_DW-1:0] calm,
  output logic              bad_time,
  output logic              bad_cal
);
  always_ff @(posedge clk) begin
    if (rst) begin
      talm <= '0;
      calm <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_TALM) talm <= wr_data & TALM_KEEP;
      if (wr_addr == A_CALM) calm <= wr_data & CALM_KEEP;
    end
  end

  logic sec_ok, min_ok, hour_ok, mon_ok, day_ok;
  always_comb begin
    sec_ok  = bcd_in_range({1'b0, talm[6:0]},   8'h00, 8'h59);
    min_ok  = bcd_in_range({1'b0, talm[14:8]},  8'h00, 8'h59);
    hour_ok = bcd_in_range({2'b0, talm[21:16]}, 8'h00, 8'h23);
    mon_ok  = bcd_in_range({3'b0, calm[20:16]}, 8'h01, 8'h12);
    day_ok  = bcd_in_range({2'b0, calm[29:24]}, 8'h01, 8'h31);
    bad_time = (talm[7] & ~sec_ok) | (talm[15] & ~min_ok) | (talm[23] & ~hour_ok);
    bad_cal  = (calm[23] & ~mon_ok) | (calm[31] & ~day_ok);
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic [REG_DW-1:0] talm,
  input  logic [REG_DW-1:0] calm,
  input  logic [REG_DW-1:0] live_time,
  input  logic [REG_DW-1:0] live_cal,
  input  logic              blocked,
  output logic              hit
);
  logic [NFIELD-1:0] fld_en, fld_ok;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    if (FLD_CAL[i] != 0) begin : g_cal
      assign fld_en[i] = calm[FLD_EN[i]];
      assign fld_ok[i] = ((calm & FLD_MASK[i]) == (live_cal & FLD_MASK[i]));
    end else begin : g_tim
      assign fld_en[i] = talm[FLD_EN[i]];
      assign fld_ok[i] = ((talm & FLD_MASK[i]) == (live_time & FLD_MASK[i]));
    end
  end

  assign hit = (|fld_en) & ~blocked & (&(fld_ok | ~fld_en));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              hit,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  output logic              flag_q,
  output logic              mask_q,
  output logic              irq
);
  logic flag_d, mask_d;
  always_comb begin
    flag_d = flag_q;
    mask_d = mask_q;
    if (wr_en && wr_addr == A_SCLR && wr_data[ALM_BIT]) flag_d = 1'b0;
    if (tick && hit) flag_d = 1'b1;
    if (wr_en && wr_addr == A_IEN  && wr_data[ALM_BIT]) mask_d = 1'b1;
    if (wr_en && wr_addr == A_IDIS && wr_data[ALM_BIT]) mask_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      mask_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_d;
      mask_q <= mask_d;
      irq    <= flag_d & mask_d;
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [23:0]       cur_time,
  input  logic [31:0]       cur_cal,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_DW-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [REG_DW-1:0] rd_data,
  output logic              irq
);
  logic [REG_DW-1:0] talm, calm;
  logic bad_time, bad_cal, hit, flag_q, mask_q;

  rtc_alarm_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .talm(talm), .calm(calm), .bad_time(bad_time), .bad_cal(bad_cal)
  );

  rtc_alarm_cmp u_cmp (
    .talm(talm), .calm(calm), .live_time({8'h00, cur_time}), .live_cal(cur_cal),
    .blocked(bad_time | bad_cal), .hit(hit)
  );

  rtc_alarm_irq u_irq (
    .clk(clk), .rst(rst), .tick(tick), .hit(hit), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .flag_q(flag_q), .mask_q(mask_q),
    .irq(irq)
  );

  logic [REG_DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_TALM:  rd_mux = talm;
      A_CALM:  rd_mux = calm;
      A_STAT:  rd_mux[ALM_BIT] = flag_q;
      A_MASK:  rd_mux[ALM_BIT] = mask_q;
      A_VALID: rd_mux = {30'd0, bad_cal, bad_time};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
  import rtc_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr,
  input logic [REG_DW-1:0] wr_data,
  input logic              flag_q,
  input logic              mask_q,
  input logic              hit,
  input logic              bad_time,
  input logic              bad_cal,
  input logic              irq
);
  assert_flag_needs_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(tick) && $past(hit));

  assert_invalid_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && (bad_time || bad_cal) && !flag_q) |=> !flag_q);

  assert_clear_works_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_SCLR && wr_data[ALM_BIT] && !tick) |=> !flag_q);

  assert_mask_set_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_IEN && wr_data[ALM_BIT]) |=> mask_q);

  assert_mask_clr_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_IDIS && wr_data[ALM_BIT]) |=> !mask_q);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag_q && mask_q));

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(wr_en && wr_addr == A_SCLR && wr_data[ALM_BIT])) |=> flag_q);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .flag_q(flag_q), .mask_q(mask_q), .hit(hit),
  .bad_time(bad_time), .bad_cal(bad_cal), .irq(irq)
);

// File: tb/test_rtc_alarm_match.sv
module test_rtc_alarm_match;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [23:0] cur_time = '0;
  logic [31:0] cur_cal = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_alarm_match i_rtc_alarm_match (
    .clk(clk), .rst(rst), .tick(tick), .cur_time(cur_time), .cur_cal(cur_cal),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R9 reset read", v, 32'h0);
    end
    chk("R9 reset irq", {31'd0, irq}, 32'h0);

    // R1 / R2 layout
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R1 time alarm readback", v, 32'h00BF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); chk("R2 date alarm readback", v, 32'hBF9F_0000);
    wr(3'd0, 32'h0); wr(3'd1, 32'h0);

    // R7 mask
    wr(3'd6, 32'hFFFF_FFFF); rd(3'd6, v); chk("R7 mask read-only", v, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF); rd(3'd6, v); chk("R7 enable sets mask", v, 32'h2);
    wr(3'd5, 32'h2);         rd(3'd6, v); chk("R7 disable clears mask", v, 32'h0);
    wr(3'd4, 32'h2);

    // R3 / R4 sweep over enable patterns and mismatching fields; year bits in live calendar
    cur_time = 24'h12_15_30;
    for (int m = 0; m < 32; m++) begin
      wr(3'd0, 32'h0012_1530 | (m[0] << 7) | (m[1] << 15) | (m[2] << 23));
      wr(3'd1, 32'h2106_0000 | (m[3] << 23) | (m[4] << 31));
      for (int k = 0; k < 6; k++) begin
        cur_time = 24'h12_15_30;
        cur_cal  = 32'h2106_2420;
        case (k)
          0: cur_time = 24'h12_15_31;
          1: cur_time = 24'h12_16_30;
          2: cur_time = 24'h13_15_30;
          3: cur_cal  = 32'h2107_2420;
          4: cur_cal  = 32'h2206_2420;
          default: ;
        endcase
        wr(3'd3, 32'h2);
        pulse();
        chk(m == 0 ? "R4 no field enabled" : "R3 enabled field match",
            {31'd0, irq},
            {31'd0, (m != 0) && (k == 5 || ((m >> k) & 1) == 0)});
      end
    end

    // R3 no tick, no flag; R10 sticky and no return without tick
    cur_time = 24'h12_15_30; cur_cal = 32'h2106_2420;
    wr(3'd0, 32'h0092_9530); wr(3'd1, 32'hA186_0000);
    wr(3'd3, 32'h2);
    repeat (4) @(negedge clk);
    chk("R3 no tick no flag", {31'd0, irq}, 32'h0);
    pulse();
    cur_time = 24'h00_00_00;
    repeat (3) @(negedge clk);
    rd(3'd2, v); chk("R10 flag sticky", v, 32'h2);
    cur_time = 24'h12_15_30;
    wr(3'd3, 32'h0); rd(3'd2, v); chk("R6 clear with zero ignored", v, 32'h2);
    wr(3'd3, 32'h2); repeat (3) @(negedge clk);
    rd(3'd2, v); chk("R10 no return without tick", v, 32'h0);

    // R6 set wins over clear
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'h2;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(3'd2, v); chk("R6 set wins over clear", v, 32'h2);

    // R8 mask gating
    wr(3'd5, 32'h2);
    chk("R8 irq low when masked", {31'd0, irq}, 32'h0);
    wr(3'd4, 32'h2);
    chk("R8 irq rises with mask", {31'd0, irq}, 32'h1);
    wr(3'd3, 32'h2);
    chk("R8 irq falls with clear", {31'd0, irq}, 32'h0);

    // R5 invalid values
    wr(3'd0, 32'h0000_00DA); cur_time = 24'h00_00_5A;
    rd(3'd7, v); chk("R5 bad seconds", v, 32'h1);
    pulse(); chk("R5 bad blocks match", {31'd0, irq}, 32'h0);
    wr(3'd0, 32'h0000_005A); rd(3'd7, v); chk("R5 disabled bad ignored", v, 32'h0);
    wr(3'd0, 32'h00A4_0000); rd(3'd7, v); chk("R5 hour 24", v, 32'h1);
    wr(3'd0, 32'h00A3_0000); rd(3'd7, v); chk("R5 hour 23 legal", v, 32'h0);
    wr(3'd0, 32'h0000_E000); rd(3'd7, v); chk("R5 minute 60", v, 32'h1);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0093_0000); rd(3'd7, v); chk("R5 month 13", v, 32'h2);
    wr(3'd1, 32'h0080_0000); rd(3'd7, v); chk("R5 month 00", v, 32'h2);
    wr(3'd1, 32'hB200_0000); rd(3'd7, v); chk("R5 date 32", v, 32'h2);
    wr(3'd1, 32'hB192_0000); rd(3'd7, v); chk("R5 date 31 month 12 legal", v, 32'h0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule